// File: doc/BRIEF.md
# SD Command Issue and Retry Sequencer

This block takes one SD card command request at a time and runs it through a separate command-path engine. The engine handles the serial line, CRC and timing. The sequencer's own work is the order of events:

1. Wipe the engine's sticky status.
2. Present the argument and a packed command word with its enable bit set.
3. Hold enable while the engine reports it is busy, then drop enable.
4. Read the final status and decide the outcome of the attempt.

When the caller marks a request as an application-specific command, every attempt is preceded by CMD55. That CMD55 carries the relative card address supplied on the `rca` input.

The sequencer makes up to a fixed number of attempts per request. It returns a one-cycle completion pulse together with a pass/fail bit. It also keeps four 32-bit response registers. Word 0 is refreshed on every attempt that expects a response. Words 1 to 3 are refreshed only when a long response ends cleanly.

Top module: `sdcmd_issuer`

## Requirements
- R1: A request on `req_valid` is taken only while `req_ready` is high. `req_ready` is high only when no request is in progress. A `req_valid` pulse during a request changes neither the commands issued nor the result.
- R2: In the cycle before each command is started, `cp_clear_bits` equals 0x7FF, which wipes all eleven sticky status bits. `cp_arg` already carries that command's argument.
- R3: The command word uses these bit positions:
  - index in bits 5:0;
  - bit 6 set when a response is wanted (short or long);
  - bit 7 set for a long response;
  - bit 10 as the start/enable bit;
  - all other bits 0.
  The word is all zero whenever enable is low.
- R4: Enable stays high while `cp_active` is high. Enable is dropped once `cp_active` is low, and the status is judged in the cycle after enable falls.
- R5: With the application flag set, CMD55 with argument `rca` and bit 6 set is issued before every attempt of the main command. If a CMD55 attempt does not succeed, the request ends at once with `ok` low.
- R6: Status bit 0 (CRC fail) or status bit 2 (timeout) on a response-expecting command fails the attempt. The exception is CRC fail without timeout while the ignore-CRC flag is set: that ends the request with `ok` high.
- R7: On a response-expecting main command, word 0 is captured on every attempt. Words 1 to 3 are captured only for a long response whose status shows bit 6 (response end) with no error. Otherwise they keep their old value.
- R8: For a command that expects no response, status bit 7 (command sent) means success, whatever the CRC bit shows.
- R9: A status with neither an error bit nor the awaited completion bit counts as a failed attempt.
- R10: A request makes at most 6 attempts of the main command. After the sixth failed attempt it ends with `ok` low. A success on the sixth attempt still reports `ok` high.
- R11: `done` is high for exactly one cycle per request. `ok` and the response registers hold until the next request updates them.
- R12: After reset, `req_ready` is 1, `done` is 0, the command word is 0 and all response registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_index | input | 6 | Command index |
| req_arg | input | 32 | Command argument |
| req_resp | input | 1 | Response expected |
| req_long | input | 1 | Long (four-word) response |
| req_app | input | 1 | Application command, prefix with CMD55 |
| req_nocrc | input | 1 | Treat CRC failure as success |
| rca | input | 32 | Argument for the CMD55 prefix |
| cp_clear_bits | output | 11 | Sticky status clear mask |
| cp_arg | output | 32 | Argument to command path |
| cp_cmd_word | output | 11 | Packed command word with enable |
| cp_active | input | 1 | Command path busy |
| cp_status | input | 11 | Command path sticky status |
| cp_rsp0 | input | 32 | Response word 0 from path |
| cp_rsp1 | input | 32 | Response word 1 from path |
| cp_rsp2 | input | 32 | Response word 2 from path |
| cp_rsp3 | input | 32 | Response word 3 from path |
| done | output | 1 | Request finished pulse |
| ok | output | 1 | Result of last request |
| rsp0 | output | 32 | Captured response word 0 |
| rsp1 | output | 32 | Captured response word 1 |
| rsp2 | output | 32 | Captured response word 2 |
| rsp3 | output | 32 | Captured response word 3 |

## Verification
The bench builds the sequencer with its default values: a 6-bit index, 32-bit argument, six attempts and prefix index 55. With the attempt limit at six, both edges of the retry limit can be reached in a short run: five failures followed by a success, and six failures in a row.

The modelled command path stays busy for three cycles per command. This makes the hold-while-busy rule and the late status sampling observable.

Because the response words encode the call number, a stale or skipped capture shows up as a wrong value.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
  // command word layout (decoded by the command path)
  localparam int CW_W    = 11;
  localparam int CW_RESP = 6;
  localparam int CW_LONG = 7;
  localparam int CW_EN   = 10;
  // sticky status layout
  localparam int ST_W    = 11;
  localparam int ST_CRC  = 0;
  localparam int ST_TMO  = 2;
  localparam int ST_REND = 6;
  localparam int ST_SENT = 7;

  typedef struct packed {
    logic resp;
    logic lng;
    logic app;
    logic nocrc;
  } cmd_flags_t;

  typedef enum logic [2:0] {
    S_IDLE, S_CLEAR, S_ISSUE, S_WAIT, S_SAMPLE
  } seq_state_t;
endpackage

// File: rtl/sdcmd_wordgen.sv
module sdcmd_wordgen
  import sdcmd_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic [IDX_W-1:0] idx,
  input  logic             resp,
  input  logic             lng,
  input  logic             en,
  output logic [CW_W-1:0]  word
);
  always_comb begin
    word = '0;
    if (en) begin
      word[IDX_W-1:0] = idx;
      word[CW_RESP]   = resp | lng;
      word[CW_LONG]   = lng;
      word[CW_EN]     = 1'b1;
    end
  end
endmodule

// File: rtl/sdcmd_judge.sv
module sdcmd_judge
  import sdcmd_pkg::*;
(
  input  logic [ST_W-1:0] status,
  input  logic            resp_exp,
  input  logic            lng,
  input  logic            nocrc,
  output logic            pass,
  output logic            cap_hi
);
  logic crc_f, tmo_f;

  always_comb begin
    crc_f  = status[ST_CRC];
    tmo_f  = status[ST_TMO];
    pass   = 1'b0;
    cap_hi = 1'b0;
    if (resp_exp) begin
      if (crc_f || tmo_f) begin
        pass = crc_f && !tmo_f && nocrc;
      end else begin
        pass   = status[ST_REND];
        cap_hi = status[ST_REND] && lng;
      end
    end else begin
      pass = status[ST_SENT];
    end
  end
endmodule

// File: rtl/sdcmd_try_ctr.sv
module sdcmd_try_ctr #(
  parameter int MAX_TRIES = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int CNT_W = $clog2(MAX_TRIES + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clr || inc) cnt_q <= cnt_d;
  end

  assign last = (cnt_q == CNT_W'(MAX_TRIES - 1));

  // R10
  try_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(MAX_TRIES));
endmodule

// File: rtl/sdcmd_issuer.sv
module sdcmd_issuer
  import sdcmd_pkg::*;
#(
  parameter int IDX_W     = 6,
  parameter int ARG_W     = 32,
  parameter int MAX_TRIES = 6,
  parameter int APP_IDX   = 55
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [IDX_W-1:0] req_index,
  input  logic [ARG_W-1:0] req_arg,
  input  logic             req_resp,
  input  logic             req_long,
  input  logic             req_app,
  input  logic             req_nocrc,
  input  logic [ARG_W-1:0] rca,
  output logic [ST_W-1:0]  cp_clear_bits,
  output logic [ARG_W-1:0] cp_arg,
  output logic [CW_W-1:0]  cp_cmd_word,
  input  logic             cp_active,
  input  logic [ST_W-1:0]  cp_status,
  input  logic [31:0]      cp_rsp0,
  input  logic [31:0]      cp_rsp1,
  input  logic [31:0]      cp_rsp2,
  input  logic [31:0]      cp_rsp3,
  output logic             done,
  output logic             ok,
  output logic [31:0]      rsp0,
  output logic [31:0]      rsp1,
  output logic [31:0]      rsp2,
  output logic [31:0]      rsp3
);
  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  seq_state_t       st_q, st_d;
  logic             pre_q, pre_d;
  logic [IDX_W-1:0] idx_q;
  logic [ARG_W-1:0] arg_q, rca_q;
  cmd_flags_t       fl_q;
  logic             done_d, ok_d;
  logic [31:0]      r0_d, r1_d, r2_d, r3_d;
  logic             ctr_clr, ctr_inc, ctr_last;

  logic [IDX_W-1:0] cur_idx;
  logic [ARG_W-1:0] cur_arg;
  logic             cur_resp, cur_lng, cur_nocrc, cur_en;
  logic             pass, cap_hi;

  // the command currently in flight: prefix or main
  always_comb begin
    cur_idx   = pre_q ? IDX_W'(APP_IDX) : idx_q;
    cur_arg   = pre_q ? rca_q : arg_q;
    cur_resp  = pre_q ? 1'b1 : (fl_q.resp | fl_q.lng);
    cur_lng   = pre_q ? 1'b0 : fl_q.lng;
    cur_nocrc = pre_q ? 1'b0 : fl_q.nocrc;
    cur_en    = (st_q == S_ISSUE) || (st_q == S_WAIT);
  end

  sdcmd_wordgen #(.IDX_W(IDX_W)) u_wordgen (
    .idx  (cur_idx),
    .resp (cur_resp),
    .lng  (cur_lng),
    .en   (cur_en),
    .word (cp_cmd_word)
  );

  sdcmd_judge u_judge (
    .status   (cp_status),
    .resp_exp (cur_resp),
    .lng      (cur_lng),
    .nocrc    (cur_nocrc),
    .pass     (pass),
    .cap_hi   (cap_hi)
  );

  sdcmd_try_ctr #(.MAX_TRIES(MAX_TRIES)) u_try_ctr (
    .clk   (clk),
    .rst_n (rst_i),
    .clr   (ctr_clr),
    .inc   (ctr_inc),
    .last  (ctr_last)
  );

  assign req_ready     = (st_q == S_IDLE);
  assign cp_clear_bits = (st_q == S_CLEAR) ? {ST_W{1'b1}} : '0;
  assign cp_arg        = cur_arg;

  // next-state logic
  always_comb begin
    st_d    = st_q;
    pre_d   = pre_q;
    done_d  = 1'b0;
    ok_d    = ok;
    r0_d    = rsp0;
    r1_d    = rsp1;
    r2_d    = rsp2;
    r3_d    = rsp3;
    ctr_clr = 1'b0;
    ctr_inc = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (req_valid) begin
          pre_d   = req_app;
          ctr_clr = 1'b1;
          st_d    = S_CLEAR;
        end
      end
      S_CLEAR: st_d = S_ISSUE;
      S_ISSUE: st_d = S_WAIT;
      S_WAIT:  if (!cp_active) st_d = S_SAMPLE;
      S_SAMPLE: begin
        if (pre_q) begin
          if (pass) begin
            pre_d = 1'b0;
            st_d  = S_CLEAR;
          end else begin
            done_d = 1'b1;
            ok_d   = 1'b0;
            st_d   = S_IDLE;
          end
        end else begin
          if (cur_resp) r0_d = cp_rsp0;
          if (cap_hi) begin
            r1_d = cp_rsp1;
            r2_d = cp_rsp2;
            r3_d = cp_rsp3;
          end
          if (pass || ctr_last) begin
            done_d = 1'b1;
            ok_d   = pass;
            st_d   = S_IDLE;
          end else begin
            ctr_inc = 1'b1;
            pre_d   = fl_q.app;
            st_d    = S_CLEAR;
          end
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      st_q  <= S_IDLE;
      pre_q <= 1'b0;
      done  <= 1'b0;
      ok    <= 1'b0;
      rsp0  <= '0;
      rsp1  <= '0;
      rsp2  <= '0;
      rsp3  <= '0;
    end else begin
      st_q  <= st_d;
      pre_q <= pre_d;
      done  <= done_d;
      ok    <= ok_d;
      rsp0  <= r0_d;
      rsp1  <= r1_d;
      rsp2  <= r2_d;
      rsp3  <= r3_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      idx_q <= '0;
      arg_q <= '0;
      rca_q <= '0;
      fl_q  <= '0;
    end else if (req_ready && req_valid) begin
      idx_q <= req_index;
      arg_q <= req_arg;
      rca_q <= rca;
      fl_q  <= '{resp: req_resp, lng: req_long, app: req_app, nocrc: req_nocrc};
    end
  end

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_i)
    done |=> !done);

  // R2
  clear_first_chk: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(cp_cmd_word[CW_EN]) |-> ($past(cp_clear_bits) == {ST_W{1'b1}}));

  // R4
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (cp_cmd_word[CW_EN] && cp_active) |=> cp_cmd_word[CW_EN]);

  // R5
  prefix_fail_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (st_q == S_SAMPLE && pre_q && !pass) |=> (done && !ok));

  // R1
  busy_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_i)
    cp_cmd_word[CW_EN] |-> !req_ready);
endmodule

// File: tb/sdcmd_issuer_bench.sv
module sdcmd_issuer_bench;
  localparam int LAT = 3;
  localparam logic [10:0] CR = 11'h001, TM = 11'h004, RE = 11'h040, SN = 11'h080;
  localparam logic [31:0] RCA = 32'hBEEF_0000;

  typedef struct packed {
    logic [5:0]       idx;
    logic [3:0]       fl;      // {resp, long, app, nocrc}
    logic [7:0][10:0] st;      // attempt status, first call at st[7]
    logic             ok;
    logic [3:0]       calls;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VT [NV] = '{
    '{6'd17, 4'b1000, {RE, 11'd0, 11'd0, 11'd0, 11'd0, 11'd0, 11'd0, 11'd0}, 1'b1, 4'd1},
    '{6'd0,  4'b0000, {SN, 11'd0, 11'd0, 11'd0, 11'd0, 11'd0, 11'd0, 11'd0}, 1'b1, 4'd1},
    '{6'd2,  4'b1100, {RE, 11'd0, 11'd0, 11'd0, 11'd0, 11'd0, 11'd0, 11'd0}, 1'b1, 4'd1},
    '{6'd8,  4'b1000, {TM, CR, RE, 11'd0, 11'd0, 11'd0, 11'd0, 11'd0}, 1'b1, 4'd3},
    '{6'd41, 4'b1011, {RE, CR, 11'd0, 11'd0, 11'd0, 11'd0, 11'd0, 11'd0}, 1'b1, 4'd2},
    '{6'd41, 4'b1010, {RE, TM, RE, RE, 11'd0, 11'd0, 11'd0, 11'd0}, 1'b1, 4'd4},
    '{6'd13, 4'b1000, {TM, TM, TM, TM, TM, TM, RE, 11'd0}, 1'b0, 4'd6},
    '{6'd7,  4'b0000, {11'd0, 11'd0, 11'd0, 11'd0, 11'd0, 11'd0, SN, 11'd0}, 1'b0, 4'd6},
    '{6'd41, 4'b1010, {TM, RE, 11'd0, 11'd0, 11'd0, 11'd0, 11'd0, 11'd0}, 1'b0, 4'd1},
    '{6'd9,  4'b1000, {11'd0, RE, 11'd0, 11'd0, 11'd0, 11'd0, 11'd0, 11'd0}, 1'b1, 4'd2},
    '{6'd18, 4'b1000, {TM, TM, TM, TM, TM, RE, 11'd0, 11'd0}, 1'b1, 4'd6},
    '{6'd24, 4'b1001, {CR | TM, RE, 11'd0, 11'd0, 11'd0, 11'd0, 11'd0, 11'd0}, 1'b1, 4'd2},
    '{6'd5,  4'b1101, {CR, 11'd0, 11'd0, 11'd0, 11'd0, 11'd0, 11'd0, 11'd0}, 1'b1, 4'd1},
    '{6'd6,  4'b0000, {CR | SN, 11'd0, 11'd0, 11'd0, 11'd0, 11'd0, 11'd0, 11'd0}, 1'b1, 4'd1}
  };
  localparam string TAG [NV] = '{
    "R6 short ok", "R8 no-resp sent", "R7 long capture", "R6 retry crc/tmo",
    "R5 R6 app nocrc", "R5 app every try", "R10 six fails", "R9 empty status",
    "R5 prefix fail", "R9 then ok", "R10 sixth ok", "R6 tmo beats nocrc",
    "R7 long nocrc keeps hi", "R8 crc ignored"
  };

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        req_valid = 1'b0, req_ready;
  logic [5:0]  req_index = '0;
  logic [31:0] req_arg = '0;
  logic        req_resp = 1'b0, req_long = 1'b0, req_app = 1'b0, req_nocrc = 1'b0;
  logic [10:0] cp_clear_bits, cp_cmd_word;
  logic [31:0] cp_arg;
  logic        cp_active;
  logic [10:0] cp_status;
  logic [31:0] cp_rsp0, cp_rsp1, cp_rsp2, cp_rsp3;
  logic        done, ok;
  logic [31:0] rsp0, rsp1, rsp2, rsp3;

  sdcmd_issuer u_sdcmd_issuer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_index(req_index), .req_arg(req_arg), .req_resp(req_resp), .req_long(req_long),
    .req_app(req_app), .req_nocrc(req_nocrc), .rca(RCA),
    .cp_clear_bits(cp_clear_bits), .cp_arg(cp_arg), .cp_cmd_word(cp_cmd_word),
    .cp_active(cp_active), .cp_status(cp_status),
    .cp_rsp0(cp_rsp0), .cp_rsp1(cp_rsp1), .cp_rsp2(cp_rsp2), .cp_rsp3(cp_rsp3),
    .done(done), .ok(ok), .rsp0(rsp0), .rsp1(rsp1), .rsp2(rsp2), .rsp3(rsp3)
  );

  function automatic logic [31:0] rw(int j, int k, logic [5:0] ix);
    return {4'(j), 20'(k), 2'b00, ix};
  endfunction

  // command path responder
  vec_t        plan = '0;
  logic        clr_log = 1'b1;
  logic        en_d = 1'b0, clr_d = 1'b0;
  int          ncall = 0, lat_cnt = 0, err_clr = 0, err_word = 0, err_en = 0;
  logic [5:0]  idx_log [16];
  logic [5:0]  ix_seen = '0;

  always @(posedge clk) begin
    en_d  <= cp_cmd_word[10];
    clr_d <= (cp_clear_bits == 11'h7FF);
    if (cp_clear_bits != 11'd0) cp_status <= cp_status & ~cp_clear_bits;
    if (clr_log) begin
      ncall <= 0; err_clr <= 0; err_word <= 0; err_en <= 0;
      cp_active <= 1'b0; cp_status <= '0; lat_cnt <= 0;
      cp_rsp0 <= '0; cp_rsp1 <= '0; cp_rsp2 <= '0; cp_rsp3 <= '0;
    end else if (cp_cmd_word[10] && !en_d) begin
      automatic logic is_pre = plan.fl[1] && (ncall % 2 == 0);
      automatic logic [5:0] e_ix = is_pre ? 6'd55 : plan.idx;
      automatic logic e_r = is_pre ? 1'b1 : (plan.fl[3] | plan.fl[2]);
      automatic logic e_l = is_pre ? 1'b0 : plan.fl[2];
      automatic logic [31:0] e_a = is_pre ? RCA : {26'h16A_0000, plan.idx};
      if (!clr_d) err_clr <= err_clr + 1;
      if (cp_cmd_word != {1'b1, 2'b00, e_l, e_r, e_ix} || cp_arg != e_a)
        err_word <= err_word + 1;
      idx_log[ncall[3:0]] <= cp_cmd_word[5:0];
      ix_seen   <= cp_cmd_word[5:0];
      cp_active <= 1'b1;
      lat_cnt   <= LAT;
    end else if (cp_active) begin
      if (!cp_cmd_word[10]) err_en <= err_en + 1;
      if (lat_cnt <= 1) begin
        cp_active <= 1'b0;
        cp_status <= (ncall < 8) ? plan.st[7 - ncall] : 11'd0;
        cp_rsp0 <= rw(0, ncall, ix_seen);
        cp_rsp1 <= rw(1, ncall, ix_seen);
        cp_rsp2 <= rw(2, ncall, ix_seen);
        cp_rsp3 <= rw(3, ncall, ix_seen);
        ncall <= ncall + 1;
      end else begin
        lat_cnt <= lat_cnt - 1;
      end
    end
  end

  int nchk = 0, nbad = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (!done && n < 3000) begin
      @(negedge clk);
      n++;
    end
    if (!done) chk({tag, " watchdog"}, 32'd0, 32'd1);
  endtask

  task automatic run_vec(input vec_t v, input string tag);
    plan = v;
    @(negedge clk) clr_log = 1'b1;
    @(negedge clk) clr_log = 1'b0;
    req_valid = 1'b1; req_index = v.idx; req_arg = {26'h16A_0000, v.idx};
    {req_resp, req_long, req_app, req_nocrc} = v.fl;
    @(negedge clk) req_valid = 1'b0;
    wait_done(tag);
    chk({tag, " ok"}, 32'(ok), 32'(v.ok));
    chk({tag, " calls R10"}, 32'(ncall), 32'(v.calls));
    chk({tag, " clear R2"}, 32'(err_clr), 0);
    chk({tag, " word R3"}, 32'(err_word), 0);
    chk({tag, " enable R4"}, 32'(err_en), 0);
    if (v.fl[1]) chk({tag, " prefix idx R5"}, 32'(idx_log[0]), 32'd55);
    if ((v.fl[3] | v.fl[2]) && !(v.fl[1] && !v.ok))
      chk({tag, " word0 R7"}, rsp0, rw(0, int'(v.calls) - 1, v.idx));
    if (v.fl[2] && v.ok && v.st[7 - (int'(v.calls) - 1)] == RE) begin
      chk({tag, " word1 R7"}, rsp1, rw(1, int'(v.calls) - 1, v.idx));
      chk({tag, " word3 R7"}, rsp3, rw(3, int'(v.calls) - 1, v.idx));
    end
    @(negedge clk);
    chk({tag, " done pulse R11"}, 32'(done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", nchk + 1, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 ready", 32'(req_ready), 1);
    chk("R12 done", 32'(done), 0);
    chk("R12 cmd word", 32'(cp_cmd_word), 0);
    chk("R12 rsp0", rsp0, 0);
    chk("R12 rsp3", rsp3, 0);

    for (int i = 0; i < NV; i++) begin
      run_vec(VT[i], TAG[i]);
      // R7: the long request with CRC ignored keeps words 1..3 from the earlier long one
      if (i == 12) chk("R7 hi words held", rsp1, rw(1, 0, 6'd2));
      // R11: ok holds after the pulse
      chk({TAG[i], " ok held R11"}, 32'(ok), 32'(VT[i].ok));
    end

    // R1: requests while busy are ignored
    plan = VT[0];
    @(negedge clk) clr_log = 1'b1;
    @(negedge clk) clr_log = 1'b0;
    req_valid = 1'b1; req_index = 6'd17; req_arg = {26'h16A_0000, 6'd17};
    {req_resp, req_long, req_app, req_nocrc} = 4'b1000;
    @(negedge clk) req_index = 6'd60; req_arg = 32'h1234_5678;
    chk("R1 ready low when busy", 32'(req_ready), 0);
    wait_done("R1 busy");
    req_valid = 1'b0;
    chk("R1 busy result", 32'(ok), 1);
    repeat (12) @(negedge clk);
    chk("R1 busy calls", 32'(ncall), 1);
    chk("R1 busy idx", 32'(idx_log[0]), 32'd17);
    chk("R1 busy word R3", 32'(err_word), 0);

    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule